// File: doc/BRIEF.md
# Transmit Phase-Alignment Sequencer

This block steps a pair of serial transmit lanes through the phase-alignment handshake that lets them bypass the transmit elastic buffer. Both lanes share one enable line and one set-phase line, so a single run of the sequence aligns the pair together. The sequencer runs on the user fabric clock. It waits for the clocks to be reported stable, raises the enable and lets it settle for a fixed number of cycles, then drives set-phase for a span that depends on the PLL divider setting. When set-phase drops, it reports the lanes as aligned.

The enable must stay high for as long as alignment is wanted, because dropping it loses the phase. It is therefore released only when the procedure has to start over. Three events invalidate an alignment: a tile reset, the PLL being powered down, and a change of clock source. Any of them sends the sequencer back to its start with every output low and its counter cleared. A loss of the clocks-stable indication before the sequence finishes also returns it to the start.

Top module: `tx_phase_align_seq`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `alignEn`, `setPhase` and `alignDone` are all low.
- R2: `alignEn` stays low while `clocksStable` is low. It goes high on the first clock edge at which `clocksStable` is sampled high, provided no restart condition is present at that edge.
- R3: `setPhase` rises exactly 32 clock edges after `alignEn` rises.
- R4: `setPhase` stays high for 4096 cycles when `divSel` is 1, 8192 when it is 2 and 16384 when it is 3.
- R5: `divSel` value 0 is unsupported and gives the longest span of 16384 cycles.
- R6: `divSel` is captured on the edge where `setPhase` rises. Changing it while `setPhase` is high has no effect on the span.
- R7: `alignDone` rises on the same edge where `setPhase` falls. `setPhase` or `alignDone` high implies `alignEn` high, and `alignEn` and `alignDone` then stay high until a restart.
- R8: A restart condition, which is `tileReset` high, `pllEnable` low or `clkSrcChange` high at a clock edge, drives all three outputs low after that edge. They stay low while the condition persists. Once it clears, the full sequence runs again with the 32-cycle settle.
- R9: `clocksStable` low during the settle or set-phase stage drives all outputs low after that edge, and the sequencer waits idle again. Once `alignDone` is high, `clocksStable` low has no effect.
- R10: `alignEn` falls only after an edge with a restart condition or with `clocksStable` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | User fabric clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clocksStable | input | 1 | High when all clocks are stable |
| divSel | input | 2 | PLL divider setting: 1, 2 or 3 (0 unsupported) |
| tileReset | input | 1 | Tile reset; high forces a restart |
| pllEnable | input | 1 | PLL power control; low (powered down) forces a restart |
| clkSrcChange | input | 1 | One-cycle pulse when the clock source changes; forces a restart |
| alignEn | output | 1 | Shared phase-align enable to both lanes |
| setPhase | output | 1 | Shared set-phase strobe to both lanes |
| alignDone | output | 1 | High once the lanes are phase aligned |

## Verification
Every output comes straight from the state register. A change in the inputs that is sampled at one edge therefore shows at the outputs right after that edge, one cycle later. The bench drives inputs just after a rising edge and samples one time unit after each later edge. It counts edges between the events: 1 edge from `clocksStable` to `alignEn`, 32 edges to `setPhase`, and the divider span until `setPhase` falls, at which point `alignDone` must already be high. A restart or a loss of `clocksStable` is checked on the sample after the first edge that sees it. The outputs are then checked on each held cycle, and after release the full sequence is counted again.

// File: rtl/tx_phase_align_pkg.sv
package tx_phase_align_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_SETTLE   = 2'd1,
    ST_SETPHASE = 2'd2,
    ST_DONE     = 2'd3
  } seqState_t;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic clear;      // hold the counter at zero
    logic loadSettle; // restart count, target = settle length
    logic loadHold;   // restart count, target = divider-chosen span
    logic advance;    // count one cycle
  } timerCtl_t;

endpackage

// File: rtl/tx_phase_align_timer.sv
module tx_phase_align_timer
  import tx_phase_align_pkg::*;
#(
  parameter int SETTLE_CYCLES = 32,
  parameter int BASE_HOLD     = 4096,
  parameter int DIV_W         = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  timerCtl_t        ctl,
  input  logic [DIV_W-1:0] divSel,
  output logic             hit
);

  localparam int MAX_SPAN = (BASE_HOLD * 4 > SETTLE_CYCLES) ? BASE_HOLD * 4 : SETTLE_CYCLES;
  localparam int CNT_W    = $clog2(MAX_SPAN) + 1;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] holdTarget;

  // divider to span: 1 -> base, 2 -> 2x, 3 and unsupported -> 4x
  always_comb begin
    case (divSel)
      DIV_W'(1): holdTarget = CNT_W'(BASE_HOLD - 1);
      DIV_W'(2): holdTarget = CNT_W'(BASE_HOLD * 2 - 1);
      default:   holdTarget = CNT_W'(BASE_HOLD * 4 - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      target <= '0;
    end else if (ctl.clear) begin
      count  <= '0;
      target <= '0;
    end else if (ctl.loadSettle) begin
      count  <= '0;
      target <= CNT_W'(SETTLE_CYCLES - 1);
    end else if (ctl.loadHold) begin
      count  <= '0;
      target <= holdTarget;
    end else if (ctl.advance) begin
      count  <= count + 1'b1;
    end
  end

  assign hit = (count == target);

endmodule

// File: rtl/tx_phase_align_ctrl.sv
module tx_phase_align_ctrl
  import tx_phase_align_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      clocksStable,
  input  logic      tileReset,
  input  logic      pllEnable,
  input  logic      clkSrcChange,
  input  logic      hit,
  output timerCtl_t ctl,
  output logic      alignEn,
  output logic      setPhase,
  output logic      alignDone
);

  seqState_t state, nextState;
  logic restart;

  assign restart = tileReset || !pllEnable || clkSrcChange;

  always_comb begin
    nextState = state;
    ctl       = '0;
    if (restart) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (clocksStable) begin
            nextState      = ST_SETTLE;
            ctl.loadSettle = 1'b1;
          end
        end
        ST_SETTLE: begin
          if (!clocksStable) begin
            nextState = ST_IDLE;
          end else if (hit) begin
            nextState    = ST_SETPHASE;
            ctl.loadHold = 1'b1;
          end else begin
            ctl.advance = 1'b1;
          end
        end
        ST_SETPHASE: begin
          if (!clocksStable) begin
            nextState = ST_IDLE;
          end else if (hit) begin
            nextState = ST_DONE;
          end else begin
            ctl.advance = 1'b1;
          end
        end
        default: nextState = ST_DONE;
      endcase
    end
    ctl.clear = (nextState == ST_IDLE) || (nextState == ST_DONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign alignEn   = (state != ST_IDLE);
  assign setPhase  = (state == ST_SETPHASE);
  assign alignDone = (state == ST_DONE);

endmodule

// File: rtl/tx_phase_align_seq.sv
module tx_phase_align_seq
  import tx_phase_align_pkg::*;
#(
  parameter int SETTLE_CYCLES = 32,
  parameter int BASE_HOLD     = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clocksStable,
  input  logic [1:0] divSel,
  input  logic       tileReset,
  input  logic       pllEnable,
  input  logic       clkSrcChange,
  output logic       alignEn,
  output logic       setPhase,
  output logic       alignDone
);

  timerCtl_t timerCtl;
  logic      timerHit;

  tx_phase_align_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .clocksStable (clocksStable),
    .tileReset    (tileReset),
    .pllEnable    (pllEnable),
    .clkSrcChange (clkSrcChange),
    .hit          (timerHit),
    .ctl          (timerCtl),
    .alignEn      (alignEn),
    .setPhase     (setPhase),
    .alignDone    (alignDone)
  );

  tx_phase_align_timer #(
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .BASE_HOLD     (BASE_HOLD),
    .DIV_W         (2)
  ) u_timer (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (timerCtl),
    .divSel (divSel),
    .hit    (timerHit)
  );

endmodule

// File: rtl/tx_phase_align_chk.sv
module tx_phase_align_chk #(
  parameter int SETTLE_CYCLES = 32
) (
  input logic clk,
  input logic rstN,
  input logic clocksStable,
  input logic tileReset,
  input logic pllEnable,
  input logic clkSrcChange,
  input logic alignEn,
  input logic setPhase,
  input logic alignDone
);

  logic [15:0] enCycles;
  logic        restartSeen;

  assign restartSeen = tileReset || !pllEnable || clkSrcChange;

  // cycles elapsed since alignEn rose, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 enCycles <= '0;
    else if (!alignEn)         enCycles <= '0;
    else if (enCycles != '1)   enCycles <= enCycles + 1'b1;
  end

  assert_en_needs_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alignEn) |-> $past(clocksStable));

  assert_settle_length_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(setPhase) |-> (enCycles == 16'(SETTLE_CYCLES)));

  assert_setphase_under_en_R7: assert property (@(posedge clk) disable iff (!rstN)
    setPhase |-> (alignEn && !alignDone));

  assert_done_under_en_R7: assert property (@(posedge clk) disable iff (!rstN)
    alignDone |-> alignEn);

  assert_done_on_fall_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(setPhase) && alignEn) |-> alignDone);

  assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    restartSeen |=> (!alignEn && !setPhase && !alignDone));

  assert_en_fall_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(alignEn) |-> $past(restartSeen || !clocksStable));

endmodule

bind tx_phase_align_seq tx_phase_align_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .clocksStable (clocksStable),
  .tileReset    (tileReset),
  .pllEnable    (pllEnable),
  .clkSrcChange (clkSrcChange),
  .alignEn      (alignEn),
  .setPhase     (setPhase),
  .alignDone    (alignDone)
);

// File: tb/tx_phase_align_seq_tb.sv
`timescale 1ns/1ps
module tx_phase_align_seq_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       clocksStable;
  logic [1:0] divSel;
  logic       tileReset;
  logic       pllEnable;
  logic       clkSrcChange;
  logic       alignEn;
  logic       setPhase;
  logic       alignDone;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tx_phase_align_seq u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .clocksStable (clocksStable),
    .divSel       (divSel),
    .tileReset    (tileReset),
    .pllEnable    (pllEnable),
    .clkSrcChange (clkSrcChange),
    .alignEn      (alignEn),
    .setPhase     (setPhase),
    .alignDone    (alignDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic outputsLow(input string req);
    check(!alignEn && !setPhase && !alignDone, req,
          {alignEn, setPhase, alignDone}, 0);
  endtask

  // count edges until alignEn (which=0) or setPhase (which=1) goes high
  task automatic edgesToRise(input int which, input int limit, output int n);
    n = 0;
    while (((which == 0) ? !alignEn : !setPhase) && n < limit) begin
      tick();
      n++;
    end
  endtask

  // full run from idle with clocksStable high; optional divSel change mid-stage
  task automatic runAlign(input int expHold, input string req,
                          input bit chgDiv, input logic [1:0] newDiv);
    int n;
    edgesToRise(0, 100, n);
    check(alignEn && n == 1, "R2", n, 1);
    edgesToRise(1, 100, n);
    check(setPhase && n == 32, "R3", n, 32);
    if (chgDiv) divSel = newDiv;
    n = 0;
    while (setPhase && n < 20000) begin
      tick();
      n++;
    end
    check(n == expHold, req, n, expHold);
    check(alignDone && alignEn, "R7", {alignEn, alignDone}, 3);
  endtask

  // kind 0: tileReset, 1: clkSrcChange, 2: pllEnable low; held for holdCyc edges
  task automatic applyRestart(input int kind, input int holdCyc);
    case (kind)
      0: tileReset = 1'b1;
      1: clkSrcChange = 1'b1;
      default: pllEnable = 1'b0;
    endcase
    for (int i = 0; i < holdCyc; i++) begin
      tick();
      outputsLow("R8");
    end
    tileReset    = 1'b0;
    clkSrcChange = 1'b0;
    pllEnable    = 1'b1;
  endtask

  task automatic testReset();
    rstN = 1'b0; clocksStable = 1'b0; divSel = 2'd1;
    tileReset = 1'b0; pllEnable = 1'b1; clkSrcChange = 1'b0;
    repeat (3) tick();
    outputsLow("R1");
    rstN = 1'b1;
    tick();
    outputsLow("R1");
    for (int i = 0; i < 20; i++) tick();
    outputsLow("R2");
  endtask

  task automatic testDiv1();
    divSel = 2'd1; clocksStable = 1'b1;
    runAlign(4096, "R4", 1'b0, 2'd0);
    for (int i = 0; i < 50; i++) tick();
    check(alignEn && alignDone && !setPhase, "R7", {alignEn, setPhase, alignDone}, 5);
  endtask

  task automatic testStableDropAfterDone();
    clocksStable = 1'b0;
    for (int i = 0; i < 5; i++) tick();
    check(alignEn && alignDone, "R9", {alignEn, alignDone}, 3);
    clocksStable = 1'b1;
  endtask

  task automatic testTileResetInDone();
    applyRestart(0, 3);
    runAlign(4096, "R8", 1'b0, 2'd0);
  endtask

  task automatic testSrcChangeInSettle();
    int n;
    applyRestart(0, 1);
    divSel = 2'd2;
    edgesToRise(0, 100, n);
    for (int i = 0; i < 10; i++) tick();
    applyRestart(1, 1);
    // span fixed by divSel=2 captured at stage start, change to 1 ignored
    runAlign(8192, "R6", 1'b1, 2'd1);
  endtask

  task automatic testPllDownInSetPhase();
    int n;
    applyRestart(0, 1);
    divSel = 2'd3;
    edgesToRise(1, 100, n);
    for (int i = 0; i < 100; i++) tick();
    applyRestart(2, 4);
    runAlign(16384, "R4", 1'b0, 2'd0);
  endtask

  task automatic testStableDropInSettle();
    int n;
    clocksStable = 1'b0;
    applyRestart(0, 1);
    clocksStable = 1'b1;
    edgesToRise(0, 100, n);
    for (int i = 0; i < 10; i++) tick();
    clocksStable = 1'b0;
    tick();
    outputsLow("R9");
    for (int i = 0; i < 20; i++) tick();
    outputsLow("R9");
  endtask

  task automatic testUnsupportedDiv();
    divSel = 2'd0;
    clocksStable = 1'b1;
    runAlign(16384, "R5", 1'b0, 2'd0);
  endtask

  initial begin
    fork
      begin
        testReset();
        testDiv1();
        testStableDropAfterDone();
        testTileResetInDone();
        testSrcChangeInSettle();
        testPllDownInSetPhase();
        testStableDropInSettle();
        testUnsupportedDiv();
      end
      begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 190000, 0);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule